// File: doc/BRIEF.md
# Divider Chain with Square-Wave Selector

This block is the time base of a real-time-clock core. A fifteen-stage binary divider advances once per reference tick. The reference tick is a clock enable at 32.768 kHz, taken from the system clock domain. A three-bit control field puts the chain in one of three states: counting, held at zero, or frozen with its count kept.

A four-bit rate code picks one of thirteen divider taps. The chosen tap appears as a square wave on an output pin when that output is enabled. Every rising edge of the chosen tap also produces a one-cycle periodic-event pulse. The available rates run from 8192 Hz down to 2 Hz. The last stage of the chain produces a one-second tick.

Releasing the chain from its held state makes the first one-second tick arrive half a second later. Software can use this to align the first time update.

Top module: `rtc_divider_sqw`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, sqw_out, periodic_pulse and second_tick are all 0. The divider count is zero.
- R2: With div_ctl equal to 3'b010, the divider count grows by one (modulo 32768) at each clock edge where ref_tick is 1. It does not change at any other edge.
- R3: With div_ctl[2:1] equal to 2'b11, the count is forced to zero and no pulse is produced. Counting resumes from zero once the code returns to 3'b010.
- R4: Every div_ctl value other than 3'b010 and 3'b11x freezes the count at its present value and produces no pulse. Counting continues from that value afterwards.
- R5: second_tick is a one-cycle pulse produced when divider bit 14 goes from 0 to 1. After release from zero, the first pulse follows 16384 ticks, and later pulses follow every 32768 ticks.
- R6: rate_sel maps to tap frequencies as follows. Code 0 selects nothing. Code 1 gives 256 Hz (bit 6). Code 2 gives 128 Hz (bit 7). Codes 3 to 15 give 8192 Hz (bit 1) down to 2 Hz (bit 13), halving at each step. Divider bit k runs at 32768/2^(k+1) Hz.
- R7: sqw_out equals the selected divider bit when sqw_en is 1 and rate_sel is nonzero. It is 0 otherwise, so it is a 50 % duty square wave.
- R8: periodic_pulse goes high for one cycle each time the selected bit goes from 0 to 1, whatever the value of sqw_en. It never goes high while rate_sel is 0.
- R9: second_tick and periodic_pulse are registered. Each is high in the clock cycle that follows the edge at which the counting tick was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | 32.768 kHz reference clock enable |
| div_ctl | input | 3 | Oscillator and divider control code |
| rate_sel | input | 4 | Tap selection code |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_out | output | 1 | Square-wave output |
| periodic_pulse | output | 1 | One-cycle pulse at each rising edge of the selected tap |
| second_tick | output | 1 | One-cycle pulse once per second |

## Verification
The hardest case to reach from the ports is the first one-second tick after release from the held state. It lies 16384 ticks away, and only a tick delivered on every clock brings it within a short run. The bench therefore drives ref_tick on every cycle for that stretch. It measures the distance to the first tick and then to the second. The same dense stimulus lets it measure the period of all thirteen tap codes in turn. The bench also freezes and clears the chain partway through a count, then checks that the square wave and the pulses resume from the right count.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

   typedef enum logic [1:0] {
      DIV_STOP = 2'd0,
      DIV_RUN  = 2'd1,
      DIV_HOLD = 2'd2
   } div_mode_e;

   // 010 counts, 11x holds at zero, anything else freezes
   function automatic div_mode_e decode_ctl(input logic [2:0] code);
      if (code[2:1] == 2'b11)  return DIV_HOLD;
      if (code == 3'b010)      return DIV_RUN;
      return DIV_STOP;
   endfunction

endpackage

// File: rtl/rtcdiv_ctl_decode.sv
module rtcdiv_ctl_decode
   import rtc_div_pkg::*;
#(
   parameter int CTL_W = 3
) (
   input  logic [CTL_W-1:0] ctl,
   output div_mode_e        mode
);

   generate
      if (CTL_W != 3) begin : g_bad_width
         $error("rtcdiv_ctl_decode: CTL_W must be 3");
      end
   endgenerate

   always_comb mode = decode_ctl(ctl);

endmodule

// File: rtl/rtcdiv_chain.sv
module rtcdiv_chain #(
   parameter int STAGES = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              clear,
   output logic [STAGES-1:0] cnt,
   output logic [STAGES-1:0] rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtcdiv_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] carry;
   logic [STAGES-1:0] cnt_q;

   assign carry[0] = advance & ~clear;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g < STAGES-1) begin : g_carry
            assign carry[g+1] = carry[g] & cnt_q[g];
         end
         assign rise[g] = carry[g] & ~cnt_q[g];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt_q[g] <= 1'b0;
            else if (clear)      cnt_q[g] <= 1'b0;
            else if (carry[g])   cnt_q[g] <= ~cnt_q[g];
         end
      end
   endgenerate

   assign cnt = cnt_q;

   p_frozen_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !clear) |=> $stable(cnt_q));

   p_tick_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/rtcdiv_tap_sel.sv
module rtcdiv_tap_sel #(
   parameter int SEL_W    = 4,
   parameter int FAST_BIT = 1,
   parameter int ALT_BIT  = 6,
   parameter int WIN_LO   = 1,
   parameter int WIN_W    = 13
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [WIN_W-1:0] lvl_win,
   input  logic [WIN_W-1:0] rise_win,
   output logic             tap_valid,
   output logic             tap_level,
   output logic             tap_rise
);

   localparam int NUM_CODES = 2 ** SEL_W;

   function automatic int tap_of(input int code);
      if (code == 1) return ALT_BIT;
      if (code == 2) return ALT_BIT + 1;
      return FAST_BIT + code - 3;
   endfunction

   generate
      if (SEL_W < 2) begin : g_bad_sel
         $error("rtcdiv_tap_sel: SEL_W must be at least 2");
      end
      if (ALT_BIT + 1 > WIN_LO + WIN_W - 1 || ALT_BIT < WIN_LO) begin : g_bad_alt
         $error("rtcdiv_tap_sel: ALT_BIT outside the tap window");
      end
   endgenerate

   logic [NUM_CODES-1:0] hit_lvl;
   logic [NUM_CODES-1:0] hit_rise;

   generate
      for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
         if (c == 0) begin : g_none
            assign hit_lvl[c]  = 1'b0;
            assign hit_rise[c] = 1'b0;
         end else begin : g_tap
            localparam int IDX = tap_of(c) - WIN_LO;
            assign hit_lvl[c]  = (sel == SEL_W'(c)) & lvl_win[IDX];
            assign hit_rise[c] = (sel == SEL_W'(c)) & rise_win[IDX];
         end
      end
   endgenerate

   assign tap_valid = |sel;
   assign tap_level = |hit_lvl;
   assign tap_rise  = |hit_rise;

endmodule

// File: rtl/rtc_divider_sqw.sv
module rtc_divider_sqw
   import rtc_div_pkg::*;
#(
   parameter int STAGES   = 15,
   parameter int SEL_W    = 4,
   parameter int FAST_BIT = 1,
   parameter int ALT_BIT  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [2:0]       div_ctl,
   input  logic [SEL_W-1:0] rate_sel,
   input  logic             sqw_en,
   output logic             sqw_out,
   output logic             periodic_pulse,
   output logic             second_tick
);

   localparam int WIN_LO = FAST_BIT;
   localparam int WIN_W  = (2 ** SEL_W) - 3;
   localparam int WIN_HI = WIN_LO + WIN_W - 1;

   generate
      if (WIN_HI > STAGES - 2) begin : g_bad_window
         $error("rtc_divider_sqw: tap window reaches the last stage");
      end
   endgenerate

   div_mode_e         mode;
   logic              advance;
   logic              clear;
   logic [STAGES-1:0] cnt_w;
   logic [STAGES-1:0] rise_w;
   logic              tap_valid;
   logic              tap_level;
   logic              tap_rise;
   logic              sec_q;
   logic              per_q;

   rtcdiv_ctl_decode #(.CTL_W(3)) u_decode (
      .ctl  (div_ctl),
      .mode (mode)
   );

   assign advance = (mode == DIV_RUN) & ref_tick;
   assign clear   = (mode == DIV_HOLD);

   rtcdiv_chain #(.STAGES(STAGES)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .clear   (clear),
      .cnt     (cnt_w),
      .rise    (rise_w)
   );

   rtcdiv_tap_sel #(
      .SEL_W    (SEL_W),
      .FAST_BIT (FAST_BIT),
      .ALT_BIT  (ALT_BIT),
      .WIN_LO   (WIN_LO),
      .WIN_W    (WIN_W)
   ) u_tap (
      .sel       (rate_sel),
      .lvl_win   (cnt_w[WIN_HI:WIN_LO]),
      .rise_win  (rise_w[WIN_HI:WIN_LO]),
      .tap_valid (tap_valid),
      .tap_level (tap_level),
      .tap_rise  (tap_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= 1'b0;
         per_q <= 1'b0;
      end else begin
         sec_q <= rise_w[STAGES-1];
         per_q <= tap_rise;
      end
   end

   assign sqw_out        = sqw_en & tap_valid & tap_level;
   assign periodic_pulse = per_q;
   assign second_tick    = sec_q;

   p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == DIV_HOLD) |=> (cnt_w == '0 && !second_tick && !periodic_pulse));

   p_sec_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      second_tick |=> !second_tick);

   p_sec_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      second_tick |-> $past(mode == DIV_RUN && ref_tick));

   p_no_tap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rate_sel) == '0) |-> !periodic_pulse);

   p_rise_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_w != '0) |=> (cnt_w != $past(cnt_w)));

endmodule

// File: tb/tb_rtc_divider_sqw.sv
module tb_rtc_divider_sqw;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic [2:0] div_ctl = 3'b000;
   logic [3:0] rate_sel = 4'd0;
   logic       sqw_en = 1'b0;
   logic       sqw_out, periodic_pulse, second_tick;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   string phase = "R1";
   bit   live = 1'b0;

   always #10 clk = ~clk;

   rtc_divider_sqw dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_ctl(div_ctl),
      .rate_sel(rate_sel), .sqw_en(sqw_en), .sqw_out(sqw_out),
      .periodic_pulse(periodic_pulse), .second_tick(second_tick)
   );

   // ---------------- reference model ----------------
   int m_cnt = 0;
   bit m_sec = 0;
   bit m_per = 0;

   function automatic int tap_bit(input int code);
      int f;
      if (code == 0) return -1;
      if (code == 1)      f = 256;
      else if (code == 2) f = 128;
      else                f = 8192 >> (code - 3);
      for (int k = 0; k < 15; k++)
         if ((32768 >> (k + 1)) == f) return k;
      return -1;
   endfunction

   always @(posedge clk) begin
      int old, k;
      if (!rst_n || div_ctl[2:1] == 2'b11) begin
         m_cnt = 0; m_sec = 0; m_per = 0;
      end else if (div_ctl == 3'b010 && ref_tick) begin
         old   = m_cnt;
         m_cnt = (m_cnt + 1) % 32768;
         m_sec = (old < 16384) && (m_cnt >= 16384);
         k     = tap_bit(int'(rate_sel));
         m_per = (k >= 0) && (((old >> k) & 1) == 0) && (((m_cnt >> k) & 1) == 1);
      end else begin
         m_sec = 0; m_per = 0;
      end
   end

   function automatic bit m_sqw();
      int k;
      k = tap_bit(int'(rate_sel));
      if (!sqw_en || k < 0) return 1'b0;
      return ((m_cnt >> k) & 1) == 1;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (live) begin
         check(sqw_out == m_sqw(), {phase, " sqw"}, sqw_out, m_sqw());
         check(periodic_pulse == m_per, {phase, " periodic"}, periodic_pulse, m_per);
         check(second_tick == m_sec, {phase, " second"}, second_tick, m_sec);
      end
   end

   // watchdog
   initial begin
      wait (cycles > 190000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic drive(input bit t, input logic [2:0] c, input logic [3:0] s, input bit e);
      #1; ref_tick = t; div_ctl = c; rate_sel = s; sqw_en = e;
   endtask

   // cycles from one rising edge of sqw_out to the next
   task automatic sqw_period(output int n);
      bit prev;
      prev = sqw_out;
      while (!(prev == 1'b0 && sqw_out == 1'b1)) begin
         prev = sqw_out; @(negedge clk);
      end
      n = 0;
      prev = sqw_out;
      do begin
         prev = sqw_out; @(negedge clk); n++;
      end while (!(prev == 1'b0 && sqw_out == 1'b1));
   endtask

   initial begin
      int n, pulses;
      bit seen_hi;
      // R1: reset state
      step(3);
      check(sqw_out == 0 && periodic_pulse == 0 && second_tick == 0, "R1 reset outputs",
            {sqw_out, periodic_pulse, second_tick}, 0);
      @(negedge clk); #1 rst_n = 1'b1;
      live = 1'b1;
      @(negedge clk);
      check(sqw_out == 0 && second_tick == 0, "R1 after release",
            {sqw_out, second_tick}, 0);

      // R4: frozen codes, ticks present
      phase = "R4 freeze";
      drive(1, 3'b000, 4'd3, 1); step(20);
      drive(1, 3'b101, 4'd3, 1); step(20);

      // R2/R6/R7: 8192 Hz, tick every clock
      phase = "R2 run";
      drive(1, 3'b010, 4'd3, 1);
      sqw_period(n);
      check(n == 4, "R6 code 3 period", n, 4);

      // R2: sparse ticks
      phase = "R2 sparse";
      for (int i = 0; i < 99; i++) begin
         drive((i % 3) == 0, 3'b010, 4'd4, 1); @(negedge clk);
      end

      // R8: pulses with output disabled
      phase = "R8 sqw off";
      drive(1, 3'b010, 4'd3, 0);
      pulses = 0; seen_hi = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         pulses += periodic_pulse;
         seen_hi |= sqw_out;
      end
      check(pulses == 16, "R8 pulses with sqw_en=0", pulses, 16);
      check(seen_hi == 0, "R7 sqw low when disabled", seen_hi, 0);

      // R8: no tap selected
      phase = "R8 no tap";
      drive(1, 3'b010, 4'd0, 1);
      pulses = 0; seen_hi = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         pulses += periodic_pulse;
         seen_hi |= sqw_out;
      end
      check(pulses == 0 && seen_hi == 0, "R8 rate code 0 silent", pulses + seen_hi, 0);

      // R4: freeze mid-count keeps state, sqw stable
      phase = "R4 mid freeze";
      drive(1, 3'b010, 4'd3, 1); step(5);
      drive(1, 3'b001, 4'd3, 1); @(negedge clk);
      seen_hi = sqw_out; pulses = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (sqw_out != seen_hi) pulses++;
      end
      check(pulses == 0, "R4 sqw stable while frozen", pulses, 0);
      drive(1, 3'b010, 4'd3, 1); step(12);

      // R3 and R5: clear, release, first second tick after 16384 ticks
      phase = "R3 hold";
      drive(1, 3'b110, 4'd3, 1); step(10);
      drive(1, 3'b111, 4'd3, 1); step(10);
      check(sqw_out == 0, "R3 sqw low in hold", sqw_out, 0);
      phase = "R5 seconds";
      drive(1, 3'b010, 4'd3, 1);
      n = 0;
      do begin @(negedge clk); n++; end while (!second_tick && n < 40000);
      check(n == 16384, "R5 first second tick", n, 16384);
      n = 0;
      do begin @(negedge clk); n++; end while (!second_tick && n < 40000);
      check(n == 32768, "R5 second tick spacing", n, 32768);

      // R6: every tap code
      phase = "R6 taps";
      for (int c = 1; c < 16; c++) begin
         int exp;
         exp = 2 << tap_bit(c);
         drive(1, 3'b010, 4'(c), 1);
         sqw_period(n);
         check(n == exp, $sformatf("R6 code %0d period", c), n, exp);
      end

      step(4);
      live = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule